// File: doc/BRIEF.md
# Tagged-FIFO Synchronous Serial Transmitter

This block turns characters queued by a host into a continuous synchronous bit stream. The host first writes the message tags it wants into a small control register: start-of-message, end-of-message, or both. It then writes an 8-bit character to the data port. The character and the current tags are stored together in one entry of a 64-entry FIFO, and the tag register clears itself after the write. On the serial side, a finite state machine reads entries from the FIFO head. Each entry's tags decide what goes on the wire: sync or flag fill, a check sequence, a run of zeros, or plain data. Because framing travels with the data, the host never has to time anything.

The block has two framing modes. In byte mode, start-tagged characters are sent as sync characters and the message body is covered by a CRC-16. In bit mode, start-tagged entries produce opening flags, the body is covered by a CRC-CCITT, and a zero is inserted after five consecutive ones. A start-tagged entry at the FIFO head raises request-to-send by itself. Bits are shifted out on a one-cycle bit-clock enable, and only after clear-to-send and modem-ready are both true.

Top module: `tagged_sync_tx`

## Requirements
- R1: A data-port write stores the character together with the start and end tags currently held in the tag register, and clears both tags. A character written without new tags is therefore sent as plain message data.
- R2: `tx_ready` is high exactly while the FIFO (64 entries by default) has a free entry, and it shows the effect of a write from the cycle after that write. Writes made while the FIFO is full are dropped.
- R3: After reset, `txd` idles at 1 and `rts` is 0. Every character and check sequence is shifted out least significant bit first, one bit per `bit_tick`.
- R4: A start-tagged entry at the FIFO head raises `rts` within two cycles. No bit is shifted until `cts` and `modem_rdy` are both 1.
- R5: In byte mode (`bit_mode`=0), the character of a start-tagged entry is sent as the sync character. That character is not covered by the CRC, and it restarts the CRC. If the FIFO runs empty inside a message, the most recent sync character is repeated as fill.
- R6: In byte mode, an end-tagged character is sent and then followed by the 16-bit CRC: reflected polynomial 0xA001, initial value 0x0000, LSB first. The transmitter then shuts down, with `rts` falling, if nothing is queued.
- R7: In bit mode (`bit_mode`=1), a start-tagged entry's character is discarded and the flag 0x7E is sent. The CRC restarts at each such flag. If the FIFO runs empty inside a frame, flags are sent as fill.
- R8: In bit mode, the first end-tagged entry sends the CRC-CCITT in place of its character: reflected polynomial 0x8408, initial value 0xFFFF, LSB first. The next end-tagged entry sends one closing flag, after which the transmitter shuts down if nothing is queued.
- R9: In bit mode, a 0 is inserted after every five consecutive 1s of data or CRC bits. Flags and zero runs never receive an inserted bit.
- R10: An entry carrying both tags sends 16 zero bits, in either mode. These bits are not covered by the CRC.
- R11: While `crc_invert` is 1, every transmitted CRC bit is inverted.
- R12: `tx_active` is set when `rts` is raised. It stays set, including after shutdown, until `act_clear` is pulsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_mode | input | 1 | 0 selects byte framing, 1 selects bit framing |
| crc_invert | input | 1 | Inverts the transmitted CRC bits |
| ctl_wr | input | 1 | Loads the tag register |
| ctl_som | input | 1 | Start-of-message tag value for `ctl_wr` |
| ctl_eom | input | 1 | End-of-message tag value for `ctl_wr` |
| data_wr | input | 1 | Pushes `data_in` and the tags into the FIFO |
| data_in | input | 8 | Character to queue |
| tx_ready | output | 1 | FIFO has a free entry |
| act_clear | input | 1 | Clears `tx_active` |
| tx_active | output | 1 | Sticky transmitter-started status |
| bit_tick | input | 1 | One-cycle bit-clock enable |
| cts | input | 1 | Clear-to-send from the line |
| modem_rdy | input | 1 | Modem ready from the line |
| txd | output | 1 | Serial transmit data |
| rts | output | 1 | Request-to-send |

## Verification
Several properties are checked on every cycle by assertions. The serializer never starts unless clear-to-send and modem-ready were both present. An inserted stuff bit is always a zero, and the ones counter never exceeds five. The line idles at mark, and the FIFO never overflows and is never read while empty. The tag register always clears after a data write, and the active status never drops without a clear command.

Some behaviours can only be shown by the bench comparing the whole bit stream against an independent model. These are: the exact order of sync, flag, zero and data units; the CRC values in both polynomials and with inversion; where stuff bits fall across the boundary between data and CRC; sync fill when the FIFO runs empty; and shutdown after the end tags.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
    localparam int CHAR_W = 8;
    localparam int UNIT_W = 16;
    localparam logic [15:0] POLY_BYTE = 16'hA001;
    localparam logic [15:0] POLY_BIT  = 16'h8408;
    localparam logic [15:0] INIT_BYTE = 16'h0000;
    localparam logic [15:0] INIT_BIT  = 16'hFFFF;
    localparam logic [7:0]  FLAG_PAT  = 8'h7E;

    typedef struct packed {
        logic              som;
        logic              eom;
        logic [CHAR_W-1:0] chr;
    } tsx_entry_t;

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} tsx_state_t;

    typedef enum logic [2:0] {K_DATA, K_SYNC, K_FLAG, K_CRC, K_ZERO} tsx_kind_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b,
                                             input logic [15:0] poly);
        return (c >> 1) ^ ((c[0] ^ b) ? poly : 16'h0000);
    endfunction
endpackage

// File: rtl/tsx_fifo.sv
module tsx_fifo
    import tsx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  tsx_entry_t wdata_i,
    input  logic       pop_i,
    output tsx_entry_t head_o,
    output logic       empty_o,
    output logic       full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [AW:0]   cnt;
    } fifo_st_t;

    fifo_st_t   q, d;
    tsx_entry_t mem [DEPTH];
    logic       do_push, do_pop;

    always_comb begin
        d       = q;
        full_o  = (q.cnt == FULL_CNT);
        empty_o = (q.cnt == '0);
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) d.wr = (q.wr == LAST_PTR) ? '0 : q.wr + 1'b1;
        if (do_pop)  d.rd = (q.rd == LAST_PTR) ? '0 : q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
        head_o = mem[q.rd];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wr] <= wdata_i;
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= FULL_CNT);
    a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/tsx_hostif.sv
module tsx_hostif (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr_i,
    input  logic ctl_som_i,
    input  logic ctl_eom_i,
    input  logic data_wr_i,
    input  logic act_set_i,
    input  logic act_clr_i,
    output logic som_o,
    output logic eom_o,
    output logic active_o
);
    typedef struct packed {
        logic som;
        logic eom;
        logic active;
    } host_st_t;

    host_st_t q, d;

    always_comb begin
        d = q;
        if (data_wr_i) begin
            d.som = 1'b0;
            d.eom = 1'b0;
        end else if (ctl_wr_i) begin
            d.som = ctl_som_i;
            d.eom = ctl_eom_i;
        end
        if (act_set_i)      d.active = 1'b1;
        else if (act_clr_i) d.active = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign som_o    = q.som;
    assign eom_o    = q.eom;
    assign active_o = q.active;

    a_r1_tags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_i |=> (!som_o && !eom_o));
    a_r12_active_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !act_clr_i) |=> active_o);
endmodule

// File: rtl/tsx_serializer.sv
module tsx_serializer
    import tsx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_i,
    input  logic       crc_inv_i,
    input  logic       bit_tick_i,
    input  logic       cts_i,
    input  logic       mrdy_i,
    input  tsx_entry_t head_i,
    input  logic       empty_i,
    output logic       pop_o,
    output logic       start_o,
    output logic       txd_o,
    output logic       rts_o
);
    typedef struct packed {
        tsx_state_t        st;
        logic [UNIT_W-1:0] sh;
        logic [4:0]        cnt;
        tsx_kind_t         kind;
        logic [2:0]        ones;
        logic              stuff;
        logic [15:0]       crc;
        logic              open;
        logic              crc_next;
        logic              eom_seen;
        logic [CHAR_W-1:0] sync;
        logic              txd;
    } ser_st_t;

    ser_st_t           q, d;
    logic [UNIT_W-1:0] ld_sh;
    logic [4:0]        ld_n;
    tsx_kind_t         ld_kind;
    logic              go, bit_v;
    logic [15:0]       poly, init;

    always_comb begin
        d       = q;
        pop_o   = 1'b0;
        start_o = 1'b0;
        ld_sh   = q.sh;
        ld_n    = q.cnt;
        ld_kind = q.kind;
        go      = 1'b0;
        bit_v   = 1'b0;
        poly    = mode_i ? POLY_BIT : POLY_BYTE;
        init    = mode_i ? INIT_BIT : INIT_BYTE;
        case (q.st)
            ST_IDLE: begin
                if (!empty_i && head_i.som) begin
                    d.st    = ST_WAIT;
                    start_o = 1'b1;
                end
            end
            ST_WAIT: begin
                if (cts_i && mrdy_i) begin
                    d.st       = ST_RUN;
                    d.cnt      = '0;
                    d.stuff    = 1'b0;
                    d.ones     = '0;
                    d.open     = 1'b0;
                    d.crc_next = 1'b0;
                    d.eom_seen = 1'b0;
                end
            end
            ST_RUN: begin
                if (bit_tick_i) begin
                    if (q.stuff) begin
                        d.txd   = 1'b0;
                        d.stuff = 1'b0;
                        d.ones  = '0;
                    end else begin
                        go = 1'b1;
                        if (q.cnt == '0) begin
                            if (!mode_i && q.crc_next) begin
                                ld_sh      = q.crc ^ {16{crc_inv_i}};
                                ld_n       = 5'd16;
                                ld_kind    = K_CRC;
                                d.crc_next = 1'b0;
                                d.open     = 1'b0;
                                d.crc      = init;
                            end else if (!empty_i) begin
                                pop_o = 1'b1;
                                if (head_i.som && head_i.eom) begin
                                    ld_sh   = '0;
                                    ld_n    = 5'd16;
                                    ld_kind = K_ZERO;
                                end else if (head_i.som) begin
                                    ld_n       = 5'd8;
                                    d.crc      = init;
                                    d.open     = 1'b1;
                                    d.eom_seen = 1'b0;
                                    if (mode_i) begin
                                        ld_sh   = {8'h00, FLAG_PAT};
                                        ld_kind = K_FLAG;
                                    end else begin
                                        ld_sh   = {8'h00, head_i.chr};
                                        ld_kind = K_SYNC;
                                        d.sync  = head_i.chr;
                                    end
                                end else if (head_i.eom) begin
                                    if (!mode_i) begin
                                        ld_sh      = {8'h00, head_i.chr};
                                        ld_n       = 5'd8;
                                        ld_kind    = K_DATA;
                                        d.crc_next = 1'b1;
                                        d.open     = 1'b1;
                                    end else if (!q.eom_seen) begin
                                        ld_sh      = q.crc ^ {16{crc_inv_i}};
                                        ld_n       = 5'd16;
                                        ld_kind    = K_CRC;
                                        d.crc      = init;
                                        d.eom_seen = 1'b1;
                                    end else begin
                                        ld_sh      = {8'h00, FLAG_PAT};
                                        ld_n       = 5'd8;
                                        ld_kind    = K_FLAG;
                                        d.open     = 1'b0;
                                        d.eom_seen = 1'b0;
                                    end
                                end else begin
                                    ld_sh      = {8'h00, head_i.chr};
                                    ld_n       = 5'd8;
                                    ld_kind    = K_DATA;
                                    d.open     = 1'b1;
                                    d.eom_seen = 1'b0;
                                end
                            end else if (q.open) begin
                                ld_n = 5'd8;
                                if (mode_i) begin
                                    ld_sh   = {8'h00, FLAG_PAT};
                                    ld_kind = K_FLAG;
                                end else begin
                                    ld_sh   = {8'h00, q.sync};
                                    ld_kind = K_SYNC;
                                end
                            end else begin
                                go    = 1'b0;
                                d.st  = ST_IDLE;
                                d.txd = 1'b1;
                            end
                        end
                        if (go) begin
                            bit_v  = ld_sh[0];
                            d.txd  = bit_v;
                            d.sh   = ld_sh >> 1;
                            d.cnt  = ld_n - 5'd1;
                            d.kind = ld_kind;
                            if (ld_kind == K_DATA) d.crc = crc_step(d.crc, bit_v, poly);
                            if (mode_i && (ld_kind == K_DATA || ld_kind == K_CRC)) begin
                                if (bit_v) begin
                                    d.ones = q.ones + 3'd1;
                                    if (q.ones == 3'd4) d.stuff = 1'b1;
                                end else begin
                                    d.ones = '0;
                                end
                            end else begin
                                d.ones = '0;
                            end
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= K_DATA;
            q.txd  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd_o = q.txd;
    assign rts_o = (q.st != ST_IDLE);

    a_r4_line_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st == ST_RUN) |-> $past(cts_i && mrdy_i));
    a_r9_stuff_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && q.stuff && bit_tick_i) |=> !txd_o);
    a_r9_ones_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.ones <= 3'd5);
    a_r3_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> txd_o);
endmodule

// File: rtl/tagged_sync_tx.sv
module tagged_sync_tx
    import tsx_pkg::*;
#(
    parameter int FIFO_DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_mode,
    input  logic       crc_invert,
    input  logic       ctl_wr,
    input  logic       ctl_som,
    input  logic       ctl_eom,
    input  logic       data_wr,
    input  logic [7:0] data_in,
    output logic       tx_ready,
    input  logic       act_clear,
    output logic       tx_active,
    input  logic       bit_tick,
    input  logic       cts,
    input  logic       modem_rdy,
    output logic       txd,
    output logic       rts
);
    logic       tag_som, tag_eom, start, pop, empty, full;
    tsx_entry_t wentry, head;

    assign wentry   = '{som: tag_som, eom: tag_eom, chr: data_in};
    assign tx_ready = !full;

    tsx_hostif u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr_i (ctl_wr),
        .ctl_som_i(ctl_som),
        .ctl_eom_i(ctl_eom),
        .data_wr_i(data_wr),
        .act_set_i(start),
        .act_clr_i(act_clear),
        .som_o    (tag_som),
        .eom_o    (tag_eom),
        .active_o (tx_active)
    );

    tsx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (data_wr),
        .wdata_i(wentry),
        .pop_i  (pop),
        .head_o (head),
        .empty_o(empty),
        .full_o (full)
    );

    tsx_serializer u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (bit_mode),
        .crc_inv_i (crc_invert),
        .bit_tick_i(bit_tick),
        .cts_i     (cts),
        .mrdy_i    (modem_rdy),
        .head_i    (head),
        .empty_i   (empty),
        .pop_o     (pop),
        .start_o   (start),
        .txd_o     (txd),
        .rts_o     (rts)
    );
endmodule

// File: tb/test_tagged_sync_tx.sv
module test_tagged_sync_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_mode = 1'b0, crc_invert = 1'b0;
    logic ctl_wr = 1'b0, ctl_som = 1'b0, ctl_eom = 1'b0;
    logic data_wr = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic act_clear = 1'b0;
    logic bit_tick = 1'b0, cts = 1'b0, modem_rdy = 1'b0;
    logic tx_ready, tx_active, txd, rts;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    logic tick_en = 1'b0;
    logic [1:0] div = '0;
    logic tick_seen = 1'b0;
    logic exp_q[$];
    string cur_tag = "R3";
    logic [15:0] m_crc, m_poly;
    int m_ones;
    logic m_mode;

    always #10 clk = ~clk;

    tagged_sync_tx i_tagged_sync_tx (
        .clk(clk), .rst_n(rst_n), .bit_mode(bit_mode), .crc_invert(crc_invert),
        .ctl_wr(ctl_wr), .ctl_som(ctl_som), .ctl_eom(ctl_eom), .data_wr(data_wr),
        .data_in(data_in), .tx_ready(tx_ready), .act_clear(act_clear),
        .tx_active(tx_active), .bit_tick(bit_tick), .cts(cts), .modem_rdy(modem_rdy),
        .txd(txd), .rts(rts)
    );

    always @(negedge clk) begin
        if (!tick_en) begin
            div      <= '0;
            bit_tick <= 1'b0;
        end else begin
            div      <= div + 2'd1;
            bit_tick <= (div == 2'd3);
        end
    end

    always @(posedge clk) tick_seen <= bit_tick;

    // Monitor: every shifted bit is popped from the scoreboard and compared
    always @(negedge clk) begin
        if (tick_seen && rts) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s unexpected bit: actual %b expected none", cur_tag, txd);
            end else begin
                logic e;
                e = exp_q.pop_front();
                if (txd !== e) begin
                    fails++;
                    $display("FAIL %s stream bit: actual %b expected %b", cur_tag, txd, e);
                end
            end
        end
    end

    task automatic check(input bit ok, input string msg, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
        end
    endtask

    function automatic logic [15:0] step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        step = {1'b0, c[15:1]};
        if (fb) step = step ^ m_poly;
    endfunction

    task automatic put_bits(input logic [15:0] v, input int n, input bit stf, input bit incl);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = v[i];
            if (incl) m_crc = step(m_crc, b);
            exp_q.push_back(b);
            if (stf && m_mode) begin
                if (b) begin
                    m_ones++;
                    if (m_ones == 5) begin
                        exp_q.push_back(1'b0);
                        m_ones = 0;
                    end
                end else m_ones = 0;
            end else m_ones = 0;
        end
    endtask

    task automatic put_crc(input logic inv);
        logic [15:0] c;
        c = m_crc ^ {16{inv}};
        put_bits(c, 16, 1'b1, 1'b0);
    endtask

    task automatic model_start(input logic md);
        m_mode = md;
        m_poly = md ? 16'h8408 : 16'hA001;
        m_crc  = md ? 16'hFFFF : 16'h0000;
        m_ones = 0;
    endtask

    task automatic wr_ctl(input logic s, input logic e);
        @(negedge clk); ctl_wr = 1'b1; ctl_som = s; ctl_eom = e;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] c);
        @(negedge clk); data_wr = 1'b1; data_in = c;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic do_reset(input logic md, input logic inv);
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; cts = 1'b0; modem_rdy = 1'b0;
        bit_mode = md; crc_invert = inv;
        repeat (3) @(negedge clk);
        exp_q.delete();
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_frame(input string tag);
        int n;
        cur_tag = tag;
        repeat (3) @(negedge clk);
        check(rts === 1'b1 && txd === 1'b1, {"R4 rts up, line held before cts / ", tag}, rts, 1);
        cts = 1'b1; modem_rdy = 1'b1;
        repeat (3) @(negedge clk);
        tick_en = 1'b1;
        n = 0;
        while (rts === 1'b1 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        tick_en = 1'b0;
        check(exp_q.size() == 0, {"R6 R8 whole frame sent then shutdown / ", tag}, exp_q.size(), 0);
        check(txd === 1'b1, {"R3 idle mark after shutdown / ", tag}, txd, 1);
        cts = 1'b0; modem_rdy = 1'b0;
    endtask

    task automatic byte_frame(input logic inv);
        do_reset(1'b0, inv);
        wr_ctl(1'b1, 1'b0); wr_data(8'h96);
        wr_ctl(1'b1, 1'b0); wr_data(8'h96);
        wr_data(8'h12);             // R1: untagged after tag clear
        wr_data(8'hA5);
        wr_ctl(1'b0, 1'b1); wr_data(8'hFF);
        model_start(1'b0);
        put_bits(16'h0096, 8, 1'b0, 1'b0);
        put_bits(16'h0096, 8, 1'b0, 1'b0);
        put_bits(16'h0012, 8, 1'b0, 1'b1);
        put_bits(16'h00A5, 8, 1'b0, 1'b1);
        put_bits(16'h00FF, 8, 1'b0, 1'b1);
        put_crc(inv);
        run_frame(inv ? "R11 inverted CRC-16" : "R1 R5 R6 byte frame");
        check(tx_active === 1'b1, "R12 active holds after shutdown", tx_active, 1);
        @(negedge clk); act_clear = 1'b1;
        @(negedge clk); act_clear = 1'b0;
        check(tx_active === 1'b0, "R12 active cleared by command", tx_active, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0, 1'b0);
        // R3 reset state
        check(txd === 1'b1, "R3 txd after reset", txd, 1);
        check(rts === 1'b0, "R3 rts after reset", rts, 0);
        check(tx_ready === 1'b1, "R2 ready after reset", tx_ready, 1);
        check(tx_active === 1'b0, "R12 active after reset", tx_active, 0);

        // R2 fill the FIFO
        wr_ctl(1'b1, 1'b0);
        for (int i = 0; i < 63; i++) wr_data(8'(i));
        check(tx_ready === 1'b1, "R2 ready with one free entry", tx_ready, 1);
        wr_data(8'h40);
        check(tx_ready === 1'b0, "R2 ready low when full", tx_ready, 0);
        wr_data(8'h41);
        check(tx_ready === 1'b0, "R2 write while full dropped", tx_ready, 0);
        check(tx_active === 1'b1 && rts === 1'b1, "R4 R12 rts and active on SOM head", rts, 1);

        byte_frame(1'b0);
        byte_frame(1'b1);

        // R7 R8 R9 bit frame with stuffing across data and CRC
        do_reset(1'b1, 1'b0);
        wr_ctl(1'b1, 1'b0); wr_data(8'h00);
        wr_data(8'hFF); wr_data(8'h3E); wr_data(8'h7E); wr_data(8'hF8);
        wr_ctl(1'b0, 1'b1); wr_data(8'h55);
        wr_ctl(1'b0, 1'b1); wr_data(8'hAA);
        model_start(1'b1);
        put_bits(16'h007E, 8, 1'b0, 1'b0);
        put_bits(16'h00FF, 8, 1'b1, 1'b1);
        put_bits(16'h003E, 8, 1'b1, 1'b1);
        put_bits(16'h007E, 8, 1'b1, 1'b1);
        put_bits(16'h00F8, 8, 1'b1, 1'b1);
        put_crc(1'b0);
        put_bits(16'h007E, 8, 1'b0, 1'b0);
        run_frame("R7 R8 R9 bit frame");

        // R10 zero run in byte mode
        do_reset(1'b0, 1'b0);
        wr_ctl(1'b1, 1'b0); wr_data(8'h33);
        wr_ctl(1'b1, 1'b1); wr_data(8'hC3);
        wr_ctl(1'b0, 1'b1); wr_data(8'h5A);
        model_start(1'b0);
        put_bits(16'h0033, 8, 1'b0, 1'b0);
        put_bits(16'h0000, 16, 1'b0, 1'b0);
        put_bits(16'h005A, 8, 1'b0, 1'b1);
        put_crc(1'b0);
        run_frame("R10 zero run");

        // R5 sync fill on underrun
        do_reset(1'b0, 1'b0);
        wr_ctl(1'b1, 1'b0); wr_data(8'h16);
        wr_data(8'h81);
        model_start(1'b0);
        put_bits(16'h0016, 8, 1'b0, 1'b0);
        put_bits(16'h0081, 8, 1'b0, 1'b1);
        put_bits(16'h0016, 8, 1'b0, 1'b0);
        put_bits(16'h0016, 8, 1'b0, 1'b0);
        cur_tag = "R5 sync fill";
        cts = 1'b1; modem_rdy = 1'b1;
        repeat (3) @(negedge clk);
        tick_en = 1'b1;
        fork
            wait (exp_q.size() == 0);
            repeat (5000) @(negedge clk);
        join_any
        disable fork;
        tick_en = 1'b0;
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R5 fill bits consumed", exp_q.size(), 0);
        check(rts === 1'b1, "R5 still open during fill", rts, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule